// File: doc/BRIEF.md
# Interleaved DMA address pattern generator

This block produces the byte addresses for a patterned memory-to-memory copy. It does not move any data. The transfer is described by a frame, which is an ordered table of up to `MAX_CHUNKS` entries. Each entry holds a chunk byte size and a gap that is skipped after the chunk. The frame is walked a programmed number of times. Each incrementing direction (source and destination) is set on its own to one of two modes: it follows the gaps (scattered), or it ignores them and runs contiguously. A direction can also be held at a fixed address for the whole transfer.

Software loads the start addresses, the mode flags, the frame count, the chunk count and the chunk table through a small register-write port. It then pulses `start`. The block emits one valid/ready beat per byte, carrying the source address, the destination address and two end markers. It can raise a one-cycle interrupt after each frame, and it pulses `done` when the transfer is over. A data mover downstream consumes the beats.

The controller is a four-state machine:
- `ST_IDLE` waits for a start.
- `ST_LOAD` fetches the current table entry, skipping it if it is empty.
- `ST_EMIT` presents the bytes of the chunk.
- `ST_FINISH` is the one-cycle done state.

Its transitions are:
- IDLE→LOAD on start.
- IDLE→FINISH on a start with zero frames or zero chunks.
- LOAD→EMIT on a non-empty entry.
- LOAD→LOAD on an empty entry that is not the final one.
- LOAD→FINISH on an empty entry that is the final one.
- EMIT→EMIT while bytes remain or ready is low.
- EMIT→LOAD on the accepted final byte of a chunk that is not the final one.
- EMIT→FINISH on the accepted final byte of the transfer.
- FINISH→IDLE, or FINISH→LOAD/FINISH on a new start.

Top module: `ilv_addr_gen`

## Requirements
- R1: Within a chunk, each incrementing direction steps its address by exactly +1 per accepted beat.
- R2: A direction with increment and scatter both set adds the chunk's gap to its address after that chunk's final byte. This includes the final chunk of a frame, so the next frame continues the gapped pattern.
- R3: A direction with increment set and scatter clear ignores all gaps and runs contiguously across chunk and frame boundaries.
- R4: A direction with increment clear keeps its start address for every beat, whatever its scatter flag.
- R5: The frame repeats the programmed frame count times. `out_last_frame` marks the final byte of the last table entry of each frame. `out_last_xfer` marks only that byte in the final frame.
- R6: With the interrupt flag set, `frame_irq` pulses once per frame, in the cycle after the frame's final beat is accepted. With the flag clear it never pulses.
- R7: A table entry of size zero emits no beats, but a scattered direction still adds its gap.
- R8: A start with frame count zero or chunk count zero asserts `done` in the next cycle, with no beats and no busy.
- R9: `start` is ignored while busy. Configuration writes are ignored while busy.
- R10: `busy` is high from the cycle after an accepted start until the final beat is accepted. `done` is high for exactly the one cycle that follows.
- R11: Addresses advance only on a cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, all beat outputs hold stable.
- R12: After reset, `out_valid`, `busy`, `done` and `frame_irq` are low.
- R13: The configuration encodings are as follows.
  - `cfg_sel` codes: 0 = source start, 1 = destination start, 2 = control, 3 = frame count, 4 = chunk count (clamped to `MAX_CHUNKS`), 5 = chunk size at `cfg_idx`, 6 = chunk gap at `cfg_idx`.
  - Control bits: bit0 = source increment, bit1 = source scatter, bit2 = destination increment, bit3 = destination scatter, bit4 = frame interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select (R13) |
| cfg_idx | input | IDX_W | Chunk table entry for size/gap writes |
| cfg_wdata | input | ADDR_W | Configuration write data |
| start | input | 1 | Begin a transfer |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Consumer accepts beat |
| out_src | output | ADDR_W | Source byte address |
| out_dst | output | ADDR_W | Destination byte address |
| out_last_frame | output | 1 | Final byte of the frame |
| out_last_xfer | output | 1 | Final byte of the transfer |
| frame_irq | output | 1 | One-cycle pulse per completed frame |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with 16-bit addresses, a four-entry table, and 4-bit size, gap and frame-count fields. With these values the full table, the largest chunk (15 bytes), the largest gap and the largest frame count (15) all fit in short runs. Starting an address near the top of the 16-bit range makes it wrap through zero during a run. These settings also allow mixed scattered, contiguous and fixed directions, empty entries, and stalled ready patterns to be compared beat by beat against a model built from the requirements.

// File: rtl/ilv_addr_pkg.sv
package ilv_addr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_EMIT,
        ST_FINISH
    } ilv_state_e;

    localparam logic [2:0] SEL_SRC_BASE = 3'd0;
    localparam logic [2:0] SEL_DST_BASE = 3'd1;
    localparam logic [2:0] SEL_CTRL     = 3'd2;
    localparam logic [2:0] SEL_NFRAMES  = 3'd3;
    localparam logic [2:0] SEL_NCHUNKS  = 3'd4;
    localparam logic [2:0] SEL_SIZE     = 3'd5;
    localparam logic [2:0] SEL_GAP      = 3'd6;

    localparam int CTL_SRC_INC = 0;
    localparam int CTL_SRC_SC  = 1;
    localparam int CTL_DST_INC = 2;
    localparam int CTL_DST_SC  = 3;
    localparam int CTL_IRQ     = 4;
    localparam int CTL_W       = 5;

    localparam int NDIR = 2;

endpackage

// File: rtl/ilv_chunk_table.sv
module ilv_chunk_table #(
    parameter int MAX_CHUNKS = 8,
    parameter int SIZE_W     = 16,
    parameter int GAP_W      = 16,
    parameter int IDX_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_size,
    input  logic              wr_gap,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SIZE_W-1:0] size_wdata,
    input  logic [GAP_W-1:0]  gap_wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [SIZE_W-1:0] rd_size,
    output logic [GAP_W-1:0]  rd_gap
);

    logic [SIZE_W-1:0] size_q [MAX_CHUNKS];
    logic [GAP_W-1:0]  gap_q  [MAX_CHUNKS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_CHUNKS; i++) begin
                size_q[i] <= '0;
                gap_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < MAX_CHUNKS; i++) begin
                if (wr_size && wr_idx == IDX_W'(i)) size_q[i] <= size_wdata;
                if (wr_gap  && wr_idx == IDX_W'(i)) gap_q[i]  <= gap_wdata;
            end
        end
    end

    assign rd_size = size_q[rd_idx];
    assign rd_gap  = gap_q[rd_idx];

endmodule

// File: rtl/ilv_dir_step.sv
module ilv_dir_step #(
    parameter int ADDR_W = 32,
    parameter int GAP_W  = 16
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic              inc_en,
    input  logic              scatter_en,
    input  logic              byte_adv,
    input  logic              gap_adv,
    input  logic [GAP_W-1:0]  gap,
    output logic [ADDR_W-1:0] nxt
);

    logic [ADDR_W-1:0] byte_term;
    logic [ADDR_W-1:0] gap_term;

    always_comb begin
        byte_term = byte_adv ? ADDR_W'(1) : '0;
        gap_term  = (scatter_en && gap_adv) ? ADDR_W'(gap) : '0;
        nxt       = inc_en ? cur + byte_term + gap_term : cur;
    end

endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
    import ilv_addr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MAX_CHUNKS = 8,
    parameter int SIZE_W     = 16,
    parameter int GAP_W      = 16,
    parameter int FRAME_W    = 16,
    localparam int IDX_W     = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1,
    localparam int CNT_W     = $clog2(MAX_CHUNKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              start,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_src,
    output logic [ADDR_W-1:0] out_dst,
    output logic              out_last_frame,
    output logic              out_last_xfer,
    output logic              frame_irq,
    output logic              busy,
    output logic              done
);

    ilv_state_e state_q, state_d;

    logic [ADDR_W-1:0]  base_q [NDIR];
    logic [CTL_W-1:0]   ctrl_q;
    logic [FRAME_W-1:0] nframes_q;
    logic [CNT_W-1:0]   nchunks_q;

    logic [ADDR_W-1:0]  cur_q  [NDIR];
    logic [ADDR_W-1:0]  nxt    [NDIR];
    logic [NDIR-1:0]    inc_en, sc_en;
    logic [FRAME_W-1:0] frame_no;
    logic [IDX_W-1:0]   chunk_no;
    logic [SIZE_W-1:0]  bytes_rem;
    logic               irq_q;

    logic [SIZE_W-1:0]  rd_size;
    logic [GAP_W-1:0]   rd_gap;

    logic cfg_ok, start_ok, empty_xfer;
    logic last_chunk, last_frame, last_byte;
    logic accept, chunk_end, src_inc_w, src_sc_w;

    assign cfg_ok     = cfg_we && !busy;
    assign start_ok   = start && (state_q == ST_IDLE || state_q == ST_FINISH);
    assign empty_xfer = (nframes_q == '0) || (nchunks_q == '0);
    assign last_chunk = (CNT_W'(chunk_no) == nchunks_q - CNT_W'(1));
    assign last_frame = (frame_no == nframes_q - FRAME_W'(1));
    assign last_byte  = (bytes_rem == '0);
    assign accept     = (state_q == ST_EMIT) && out_ready;
    assign chunk_end  = ((state_q == ST_LOAD) && (rd_size == '0)) || (accept && last_byte);
    assign src_inc_w  = ctrl_q[CTL_SRC_INC];
    assign src_sc_w   = ctrl_q[CTL_SRC_SC];

    assign inc_en = {ctrl_q[CTL_DST_INC], ctrl_q[CTL_SRC_INC]};
    assign sc_en  = {ctrl_q[CTL_DST_SC],  ctrl_q[CTL_SRC_SC]};

    ilv_chunk_table #(
        .MAX_CHUNKS(MAX_CHUNKS), .SIZE_W(SIZE_W), .GAP_W(GAP_W), .IDX_W(IDX_W)
    ) table_i (
        .clk(clk), .rst_n(rst_n),
        .wr_size(cfg_ok && cfg_sel == SEL_SIZE),
        .wr_gap(cfg_ok && cfg_sel == SEL_GAP),
        .wr_idx(cfg_idx),
        .size_wdata(cfg_wdata[SIZE_W-1:0]),
        .gap_wdata(cfg_wdata[GAP_W-1:0]),
        .rd_idx(chunk_no),
        .rd_size(rd_size),
        .rd_gap(rd_gap)
    );

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        ilv_dir_step #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) step_i (
            .cur(cur_q[d]),
            .inc_en(inc_en[d]),
            .scatter_en(sc_en[d]),
            .byte_adv(accept),
            .gap_adv(chunk_end),
            .gap(rd_gap),
            .nxt(nxt[d])
        );
    end

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q[0] <= '0;
            base_q[1] <= '0;
            ctrl_q    <= '0;
            nframes_q <= '0;
            nchunks_q <= '0;
        end else if (cfg_ok) begin
            unique case (cfg_sel)
                SEL_SRC_BASE: base_q[0] <= cfg_wdata;
                SEL_DST_BASE: base_q[1] <= cfg_wdata;
                SEL_CTRL:     ctrl_q    <= cfg_wdata[CTL_W-1:0];
                SEL_NFRAMES:  nframes_q <= cfg_wdata[FRAME_W-1:0];
                SEL_NCHUNKS:  nchunks_q <= (cfg_wdata > ADDR_W'(MAX_CHUNKS)) ?
                                           CNT_W'(MAX_CHUNKS) : cfg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FINISH: begin
                if (start_ok) state_d = empty_xfer ? ST_FINISH : ST_LOAD;
                else          state_d = ST_IDLE;
            end
            ST_LOAD: begin
                if (rd_size != '0)                state_d = ST_EMIT;
                else if (last_chunk && last_frame) state_d = ST_FINISH;
                else                              state_d = ST_LOAD;
            end
            ST_EMIT: begin
                if (accept && last_byte)
                    state_d = (last_chunk && last_frame) ? ST_FINISH : ST_LOAD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Walk counters and addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q[0]  <= '0;
            cur_q[1]  <= '0;
            frame_no  <= '0;
            chunk_no  <= '0;
            bytes_rem <= '0;
            irq_q     <= 1'b0;
        end else begin
            irq_q <= chunk_end && last_chunk && ctrl_q[CTL_IRQ];
            if (start_ok) begin
                cur_q[0] <= base_q[0];
                cur_q[1] <= base_q[1];
                frame_no <= '0;
                chunk_no <= '0;
            end else begin
                cur_q[0] <= nxt[0];
                cur_q[1] <= nxt[1];
                if (state_q == ST_LOAD && rd_size != '0)
                    bytes_rem <= rd_size - SIZE_W'(1);
                else if (accept && !last_byte)
                    bytes_rem <= bytes_rem - SIZE_W'(1);
                if (chunk_end) begin
                    if (last_chunk) begin
                        chunk_no <= '0;
                        frame_no <= frame_no + FRAME_W'(1);
                    end else begin
                        chunk_no <= chunk_no + IDX_W'(1);
                    end
                end
            end
        end
    end

    // Outputs
    always_comb begin
        out_valid      = (state_q == ST_EMIT);
        busy           = (state_q == ST_LOAD) || (state_q == ST_EMIT);
        done           = (state_q == ST_FINISH);
        out_src        = cur_q[0];
        out_dst        = cur_q[1];
        out_last_frame = out_valid && last_byte && last_chunk;
        out_last_xfer  = out_last_frame && last_frame;
        frame_irq      = irq_q;
    end

endmodule

// File: rtl/ilv_addr_gen_chk.sv
module ilv_addr_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_src,
    input logic [ADDR_W-1:0] out_dst,
    input logic              out_last_frame,
    input logic              out_last_xfer,
    input logic              busy,
    input logic              done,
    input logic              src_inc,
    input logic              src_sc
);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_src) && $stable(out_dst)
            && $stable(out_last_frame) && $stable(out_last_xfer));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_novalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid);

    p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_xfer_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last_xfer |-> out_last_frame);

    p_fixed_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !src_inc && !out_last_xfer |=> $stable(out_src));

    p_contig_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && src_inc && !src_sc && !out_last_xfer
            |=> out_src == $past(out_src) + ADDR_W'(1));

endmodule

bind ilv_addr_gen ilv_addr_gen_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_src(out_src), .out_dst(out_dst),
    .out_last_frame(out_last_frame), .out_last_xfer(out_last_xfer),
    .busy(busy), .done(done),
    .src_inc(src_inc_w), .src_sc(src_sc_w)
);

// File: tb/ilv_addr_gen_tb_top.sv
module ilv_addr_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int NV = 6;
    localparam int MAXB = 512;

    localparam logic [15:0] V_SRC [NV] = '{16'h0100, 16'h0300, 16'h0500, 16'h0700, 16'h0900, 16'hFFF0};
    localparam logic [15:0] V_DST [NV] = '{16'h0200, 16'h0400, 16'h0600, 16'h0800, 16'h0A00, 16'h1000};
    localparam logic [4:0]  V_CTL [NV] = '{5'b10111, 5'b01111, 5'b11110, 5'b11011, 5'b10101, 5'b11111};
    localparam int          V_NF  [NV] = '{2, 3, 2, 2, 1, 15};
    localparam int          V_NC  [NV] = '{3, 2, 2, 3, 4, 1};
    localparam logic [15:0] V_SZ  [NV] = '{16'h0312, 16'h0023, 16'h0021, 16'h0102, 16'hF111, 16'h0001};
    localparam logic [15:0] V_GP  [NV] = '{16'h0021, 16'h0014, 16'h0033, 16'h0251, 16'h120F, 16'h0002};
    localparam int          V_RM  [NV] = '{0, 1, 0, 2, 1, 2};
    localparam string       V_REQ [NV] = '{"R2", "R2", "R4", "R7", "R3", "R5"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic start = 1'b0;
    logic out_ready = 1'b0;
    logic out_valid, out_last_frame, out_last_xfer, frame_irq, busy, done;
    logic [AW-1:0] out_src, out_dst;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [33:0] exp_beat [MAXB];
    int exp_n;
    int exp_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilv_addr_gen #(
        .ADDR_W(AW), .MAX_CHUNKS(4), .SIZE_W(4), .GAP_W(4), .FRAME_W(4)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .start(start),
        .out_valid(out_valid), .out_ready(out_ready), .out_src(out_src),
        .out_dst(out_dst), .out_last_frame(out_last_frame),
        .out_last_xfer(out_last_xfer), .frame_irq(frame_irq),
        .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [1:0] idx, input logic [AW-1:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic program_vec(input int v);
        cfg_write(3'd0, 2'd0, V_SRC[v]);
        cfg_write(3'd1, 2'd0, V_DST[v]);
        cfg_write(3'd2, 2'd0, AW'(V_CTL[v]));
        cfg_write(3'd3, 2'd0, AW'(V_NF[v]));
        cfg_write(3'd4, 2'd0, AW'(V_NC[v]));
        for (int i = 0; i < 4; i++) begin
            cfg_write(3'd5, 2'(i), AW'(V_SZ[v][i*4 +: 4]));
            cfg_write(3'd6, 2'(i), AW'(V_GP[v][i*4 +: 4]));
        end
    endtask

    // Reference model built from R1-style rules written out per requirement
    task automatic build_exp(input int v);
        logic [AW-1:0] a_s, a_d;
        logic [3:0] sz, gp;
        bit si, ss, di, ds;
        a_s = V_SRC[v]; a_d = V_DST[v];
        si = V_CTL[v][0]; ss = V_CTL[v][1]; di = V_CTL[v][2]; ds = V_CTL[v][3];
        exp_n = 0;
        exp_irq = V_CTL[v][4] ? V_NF[v] : 0;
        for (int f = 0; f < V_NF[v]; f++) begin
            for (int c = 0; c < V_NC[v]; c++) begin
                sz = V_SZ[v][c*4 +: 4];
                gp = V_GP[v][c*4 +: 4];
                for (int b = 0; b < int'(sz); b++) begin
                    exp_beat[exp_n] = {a_s, a_d,
                        (c == V_NC[v]-1) && (b == int'(sz)-1),
                        (c == V_NC[v]-1) && (b == int'(sz)-1) && (f == V_NF[v]-1)};
                    exp_n++;
                    if (si) a_s = a_s + 1'b1;
                    if (di) a_d = a_d + 1'b1;
                end
                if (si && ss) a_s = a_s + AW'(gp);
                if (di && ds) a_d = a_d + AW'(gp);
            end
        end
    endtask

    task automatic run_xfer(input int rmode, input bit poke, input string req);
        int k, irqs, cyc;
        bit held, seen_done, busy_ok;
        logic [33:0] held_val, cur;
        k = 0; irqs = 0; held = 1'b0; seen_done = 1'b0; busy_ok = 1'b1;
        start = 1'b1;
        for (cyc = 0; cyc < 4000 && !seen_done; cyc++) begin
            @(negedge clk);
            if (poke && cyc == 3) begin
                cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 16'hAAAA; start = 1'b1;
            end else begin
                cfg_we = 1'b0; start = 1'b0;
            end
            unique case (rmode)
                0: out_ready = 1'b1;
                1: out_ready = (cyc % 3) != 0;
                default: out_ready = (cyc % 2) == 1;
            endcase
            cur = {out_src, out_dst, out_last_frame, out_last_xfer};
            if (held)
                check(out_valid && cur == held_val, "R11", "hold while stalled",
                      64'(cur), 64'(held_val));
            held = 1'b0;
            if (k < exp_n && !busy) busy_ok = 1'b0;
            if (out_valid) begin
                if (out_ready) begin
                    if (k < MAXB)
                        check(k < exp_n && cur == exp_beat[k], req, $sformatf("beat %0d", k),
                              64'(cur), 64'(exp_beat[k]));
                    k++;
                end else begin
                    held = 1'b1; held_val = cur;
                end
            end
            if (frame_irq) irqs++;
            if (done) seen_done = 1'b1;
        end
        cfg_we = 1'b0; start = 1'b0;
        check(seen_done, "R10", "done seen", 64'(seen_done), 64'd1);
        check(!busy, "R10", "busy low with done", 64'(busy), 64'd0);
        check(busy_ok, "R10", "busy held until last beat", 64'(busy_ok), 64'd1);
        check(k == exp_n, "R5", "beat count", 64'(k), 64'(exp_n));
        check(irqs == exp_irq, "R6", "frame irq count", 64'(irqs), 64'(exp_irq));
        @(negedge clk);
        check(!done, "R10", "done one cycle", 64'(done), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        if (!finished) $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check(!out_valid, "R12", "valid after reset", 64'(out_valid), 64'd0);
        check(!busy, "R12", "busy after reset", 64'(busy), 64'd0);
        check(!done, "R12", "done after reset", 64'(done), 64'd0);
        check(!frame_irq, "R12", "irq after reset", 64'(frame_irq), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R11 R13
        for (int v = 0; v < NV; v++) begin
            program_vec(v);
            build_exp(v);
            run_xfer(V_RM[v], 1'b0, V_REQ[v]);
            @(negedge clk);
        end

        // R9: start and config write during a run are ignored
        program_vec(1);
        build_exp(1);
        run_xfer(1, 1'b1, "R9");
        @(negedge clk);
        run_xfer(0, 1'b0, "R9");
        @(negedge clk);

        // R8: zero frames
        cfg_write(3'd3, 2'd0, 16'd0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done && !busy && !out_valid, "R8", "zero frames done",
              64'({done, busy, out_valid}), 64'b100);
        @(negedge clk);
        check(!done && !out_valid, "R8", "zero frames after", 64'({done, out_valid}), 64'b00);

        // R8: zero chunks
        cfg_write(3'd3, 2'd0, 16'd2);
        cfg_write(3'd4, 2'd0, 16'd0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done && !busy && !out_valid, "R8", "zero chunks done",
              64'({done, busy, out_valid}), 64'b100);
        @(negedge clk);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule